// File: doc/BRIEF.md
# Byte-Wide Asynchronous Serial Adapter

This block connects a byte-wide processor bus to one asynchronous serial line. A single address bit selects one of two register pairs. A write at address 0 goes to the control register and a read at address 0 returns status. A write at address 1 loads the transmit holding byte and a read at address 1 returns the last received character. A transmit shifter takes each byte from the holding register and frames it on `txd`. A receive shifter samples `rxd` in the middle of each bit and commits each complete character to the receive register.

Both shifters advance on `baud_tick`, divided by 1, 16 or 64. The fourth divider code holds both shifters and all status flags in reset. One active-low interrupt line is rebuilt every clock from the live status bits. It has two enables: one for the receive side (character waiting, carrier lost, overrun) and one for the transmit side (holding register empty and clear-to-send active). `cts_n` and `dcd_n` are assumed synchronous to `clk`. `rxd` is synchronised inside the block.

Top module: `serial_adapter`

## Requirements
- R1: Register access.
  - With `addr`=1, a read returns the receive register and a write loads the transmit holding register.
  - With `addr`=0, a read returns status and a write loads control.
  - A holding register that is loaded while the shifter is busy keeps its byte, and status bit 1 reads 0, until the current frame ends.
- R2: After `rst_n`, control resets to the held-reset code 0x03.
  - `irq_n`=1 and `txd`=1.
  - With `cts_n`=0 and `dcd_n`=0, status reads 0x02.
- R3: Status bit 3 reflects `cts_n`. While `cts_n`=1, status bit 1 (transmit empty) reads 0 whatever the holding register holds, and no new frame starts.
- R4: Transmit frame format.
  - A frame is a 0 start bit, then the data bits LSB first, then an optional parity bit, then 1 or 2 stop bits at 1.
  - Control bits 4:2 pick the format: 000 7E2, 001 7O2, 010 7E1, 011 7O1, 100 8N2, 101 8N1, 110 8E1, 111 8O1.
  - Control bits 1:0 pick the divider: 00 ÷1, 01 ÷16, 10 ÷64. Each bit lasts that many `baud_tick` pulses.
- R5: Receive.
  - A start bit counts only after the line has been seen high while idle.
  - After the data, parity and first stop bit have been sampled, the character goes to the receive register. For 7-bit formats, bit 7 reads 0.
  - Status bit 0 is then set, bit 4 shows a low stop bit and bit 6 shows a parity mismatch.
  - A data read clears bit 0.
- R6: Overrun.
  - If a character completes while bit 0 is still set, it is discarded and status bit 5 is set.
  - Bit 5 is cleared only by a status read followed by a data read.
- R7: A rising edge on `dcd_n` sets status bit 2. Bit 2 is cleared by a status read followed by a data read, even if `dcd_n` stays high.
- R8: Control bit 7 enables the receive interrupt. While it is set, the interrupt asserts when any of status bits 0, 2 or 5 is set. While it is clear, these bits leave `irq_n` high.
- R9: Control bits 6:5 = 01 enables the transmit interrupt. The interrupt then asserts while status bit 1 is set. Other codes leave `irq_n` high for this cause.
- R10: While control bits 1:0 = 11:
  - receive full, overrun, lost carrier and the error flags clear;
  - the holding register empties and data writes are dropped;
  - both shifters go idle and `txd` stays 1.
- R11: `irq_n` is registered. It changes on the clock edge after the one that changes the status bits. Status bit 7 equals the inverse of `irq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Bus access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 1 | 0 = control/status, 1 = data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| irq_n | output | 1 | Interrupt request, active low |
| baud_tick | input | 1 | Bit clock enable, before division |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| cts_n | input | 1 | Clear to send, active low |
| dcd_n | input | 1 | Carrier detect, active low |

## Verification
Transmission is checked in four word formats: 8N1, 7E1, 8O1 and 7O2. Together they separate data width, parity sense and stop-bit count. Divider ratios ÷1 and ÷64 are measured by the length of the start bit, which exposes a wrong ratio or a late reload.

On the receive side, the bench sends a clean character, one with a low stop bit, one with wrong parity, and back-to-back characters with no read between them. These separate commit, the framing flag, the parity flag and overrun. Separate scenarios cover:
- clear-to-send toggling;
- a carrier drop;
- a disabled interrupt enable;
- a master reset while a byte is held.

These isolate the gating, the latched carrier flag, the interrupt masking and the reset clearing.

// File: rtl/serial_adapter.sv
module serial_adapter #(
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       we,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_n,
  input  logic       baud_tick,
  output logic       txd,
  input  logic       rxd,
  input  logic       cts_n,
  input  logic       dcd_n
);
  localparam int CW = $clog2(DIV_SLOW);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

  logic [7:0] ctrl;
  logic       mreset, nd8, par_en, odd, stop2, rie, tie;
  logic       wr_ctl, wr_dat, rd_st, rd_dat;
  logic [CW-1:0] divm1, half;

  assign mreset = (ctrl[1:0] == 2'b11);
  assign nd8    = ctrl[4];
  assign par_en = ~ctrl[4] | ctrl[3];
  assign odd    = ctrl[2];
  assign stop2  = ~ctrl[3] & (~ctrl[4] | ~ctrl[2]);
  assign rie    = ctrl[7];
  assign tie    = (ctrl[6:5] == 2'b01);

  assign wr_ctl = cs & we & ~addr;
  assign wr_dat = cs & we & addr;
  assign rd_st  = cs & ~we & ~addr;
  assign rd_dat = cs & ~we & addr;

  always_comb begin
    case (ctrl[1:0])
      2'b01:   begin divm1 = CW'(DIV_MID - 1);  half = CW'(DIV_MID / 2 - 1);  end
      2'b10:   begin divm1 = CW'(DIV_SLOW - 1); half = CW'(DIV_SLOW / 2 - 1); end
      default: begin divm1 = '0;                half = '0;                    end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctrl <= 8'h03;
    else if (wr_ctl) ctrl <= wdata;

  // transmit side
  logic [7:0]    hold;
  logic          hold_full, pbit, tx_busy;
  logic [11:0]   tx_sh, fr;
  logic [3:0]    tx_left, flen;
  logic [CW-1:0] tx_cnt;

  assign pbit    = (nd8 ? ^hold : ^hold[6:0]) ^ odd;
  assign flen    = 4'd1 + (nd8 ? 4'd8 : 4'd7) + {3'b000, par_en} + (stop2 ? 4'd2 : 4'd1);
  assign tx_busy = (tx_left != 4'd0);
  assign txd     = tx_busy ? tx_sh[0] : 1'b1;

  always_comb begin
    fr    = '1;
    fr[0] = 1'b0;
    if (nd8) begin
      fr[8:1] = hold;
      if (par_en) fr[9] = pbit;
    end else begin
      fr[7:1] = hold[6:0];
      if (par_en) fr[8] = pbit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0; hold_full <= 1'b0; tx_sh <= '1; tx_left <= '0; tx_cnt <= '0;
    end else if (mreset) begin
      hold_full <= 1'b0; tx_sh <= '1; tx_left <= '0; tx_cnt <= '0;
    end else begin
      if (!tx_busy) begin
        if (hold_full && !cts_n) begin
          tx_sh     <= fr;
          tx_left   <= flen;
          tx_cnt    <= divm1;
          hold_full <= 1'b0;
        end
      end else if (baud_tick) begin
        if (tx_cnt == '0) begin
          tx_sh   <= {1'b1, tx_sh[11:1]};
          tx_left <= tx_left - 4'd1;
          tx_cnt  <= divm1;
        end else begin
          tx_cnt <= tx_cnt - 1'b1;
        end
      end
      if (wr_dat) begin
        hold      <= wdata;
        hold_full <= 1'b1;
      end
    end
  end

  // receive side
  rx_state_t     rx_st;
  logic          rx_s1, rx_s2, rx_arm, rx_done, p_got, stop_got, p_err;
  logic [CW-1:0] rx_cnt;
  logic [3:0]    rx_n, target;
  logic [8:0]    rx_sh;
  logic [9:0]    rx_vec, rx_al;
  logic [7:0]    rx_byte;

  assign target   = (nd8 ? 4'd8 : 4'd7) + {3'b000, par_en} + 4'd1;
  assign rx_vec   = {rx_s2, rx_sh};
  assign rx_al    = rx_vec >> (4'd10 - target);
  assign rx_byte  = nd8 ? rx_al[7:0] : {1'b0, rx_al[6:0]};
  assign p_got    = nd8 ? rx_al[8] : rx_al[7];
  assign stop_got = rx_al[target - 4'd1];
  assign p_err    = par_en & (p_got != ((^rx_byte) ^ odd));
  assign rx_done  = baud_tick & ~mreset & (rx_st == RX_BITS) & (rx_cnt == '0)
                  & ((rx_n + 4'd1) == target);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin rx_s1 <= 1'b1; rx_s2 <= 1'b1; end
    else        begin rx_s1 <= rxd;  rx_s2 <= rx_s1; end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st <= RX_IDLE; rx_cnt <= '0; rx_n <= '0; rx_sh <= '0; rx_arm <= 1'b0;
    end else if (mreset) begin
      rx_st <= RX_IDLE; rx_cnt <= '0; rx_n <= '0; rx_arm <= 1'b0;
    end else if (baud_tick) begin
      case (rx_st)
        RX_IDLE:
          if (rx_s2) rx_arm <= 1'b1;
          else if (rx_arm) begin
            rx_arm <= 1'b0;
            rx_n   <= '0;
            if (ctrl[1:0] == 2'b00) begin rx_st <= RX_BITS;  rx_cnt <= '0;   end
            else                    begin rx_st <= RX_START; rx_cnt <= half; end
          end
        RX_START:
          if (rx_cnt != '0) rx_cnt <= rx_cnt - 1'b1;
          else if (!rx_s2) begin rx_st <= RX_BITS; rx_cnt <= divm1; end
          else rx_st <= RX_IDLE;
        RX_BITS:
          if (rx_cnt != '0) rx_cnt <= rx_cnt - 1'b1;
          else begin
            rx_sh  <= rx_vec[9:1];
            rx_n   <= rx_n + 4'd1;
            rx_cnt <= divm1;
            if ((rx_n + 4'd1) == target) rx_st <= RX_IDLE;
          end
        default: rx_st <= RX_IDLE;
      endcase
    end
  end

  // status flags
  logic [7:0] rx_data, stat;
  logic       rdrf, ovr, lost, fe, pe, st_seen, dcd_q, irq_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rdrf <= 1'b0; ovr <= 1'b0; lost <= 1'b0;
      fe <= 1'b0; pe <= 1'b0; st_seen <= 1'b0; dcd_q <= 1'b1;
    end else begin
      dcd_q <= dcd_n;
      if (mreset) begin
        rdrf <= 1'b0; ovr <= 1'b0; lost <= 1'b0; fe <= 1'b0; pe <= 1'b0; st_seen <= 1'b0;
      end else begin
        if (rd_st) st_seen <= 1'b1;
        if (rd_dat) begin
          rdrf    <= 1'b0;
          st_seen <= 1'b0;
          if (st_seen) begin ovr <= 1'b0; lost <= 1'b0; end
        end
        if (dcd_n && !dcd_q) lost <= 1'b1;
        if (rx_done) begin
          if (rdrf && !rd_dat) ovr <= 1'b1;
          else begin
            rx_data <= rx_byte;
            rdrf    <= 1'b1;
            fe      <= ~stop_got;
            pe      <= p_err;
          end
        end
      end
    end
  end

  assign stat     = {~irq_n, pe, ovr, fe, cts_n, lost, ~hold_full & ~cts_n, rdrf};
  assign irq_cond = (rie & (rdrf | lost | ovr)) | (tie & stat[1]);
  assign rdata    = addr ? rx_data : stat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~irq_cond;

endmodule

// File: rtl/serial_adapter_chk.sv
module serial_adapter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       we,
  input logic       addr,
  input logic       txd,
  input logic       irq_n,
  input logic       cts_n,
  input logic [7:0] ctrl,
  input logic [7:0] stat,
  input logic       rx_done
);
  p_cts_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cts_n |-> !stat[1]);

  p_rdrf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && addr && !rx_done) |=> !stat[0]);

  p_ovr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[5] && !(cs && !we && addr) && ctrl[1:0] != 2'b11) |=> stat[5]);

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[7] && ctrl[6:5] != 2'b01) |=> irq_n);

  p_txd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[1:0] == 2'b11) |=> txd);

  p_irq_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat[0]) && ctrl[7] && !cs) |=> !irq_n);
endmodule

bind serial_adapter serial_adapter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .txd(txd),
  .irq_n(irq_n), .cts_n(cts_n), .ctrl(ctrl), .stat(stat), .rx_done(rx_done)
);

// File: tb/serial_adapter_tb_top.sv
`timescale 1ns/1ps
module serial_adapter_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, cs = 1'b0, we = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       irq_n, txd;
  logic       baud_tick = 1'b1, rxd = 1'b1, cts_n = 1'b0, dcd_n = 1'b0;
  int checks = 0, errors = 0;

  serial_adapter dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_n(irq_n), .baud_tick(baud_tick), .txd(txd), .rxd(rxd),
    .cts_n(cts_n), .dcd_n(dcd_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 1'b0;
  endtask

  task automatic mk(input logic [7:0] d, input int nd, input int par, input bit odd,
                    input int ns, input bit bad_par, input bit bad_stop,
                    output logic [11:0] f, output int len);
    logic p;
    f = '1; f[0] = 1'b0; p = odd;
    for (int i = 0; i < nd; i++) begin f[1+i] = d[i]; p ^= d[i]; end
    if (par != 0) f[1+nd] = p ^ bad_par;
    if (bad_stop) f[1+nd+par] = 1'b0;
    len = 1 + nd + par + ns;
  endtask

  task automatic ser_send(input logic [11:0] f, input int len, input int div);
    for (int i = 0; i < len; i++) begin rxd = f[i]; repeat (div) @(negedge clk); end
    rxd = 1'b1;
    repeat (div) @(negedge clk);
  endtask

  task automatic ser_grab(input int len, input int div, output logic [11:0] f);
    int w = 0;
    f = '1;
    while (txd === 1'b1 && w < 5000) begin @(negedge clk); w++; end
    repeat (div / 2) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      f[i] = txd;
      if (i < len - 1) repeat (div) @(negedge clk);
    end
  endtask

  task automatic low_len(output int n);
    int w = 0;
    n = 0;
    while (txd === 1'b1 && w < 5000) begin @(negedge clk); w++; end
    while (txd === 1'b0 && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset;
    logic [7:0] s;
    chk("R2 irq_n", irq_n, 1'b1);
    chk("R2 txd", txd, 1'b1);
    bus_rd(0, s); chk("R2 status", s, 8'h02);
    bus_rd(1, s); chk("R1 data reg after reset", s, 8'h00);
  endtask

  task automatic t_cts;
    logic [7:0] s;
    bus_wr(0, 8'h35);
    repeat (2) @(negedge clk);
    chk("R9 tx irq asserted", irq_n, 1'b0);
    cts_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_rd(0, s); chk("R3 status with cts high", s, 8'h08);
    chk("R9 tx irq gated by cts", irq_n, 1'b1);
    cts_n = 1'b0;
    bus_wr(0, 8'h55);
    repeat (2) @(negedge clk);
    chk("R9 code 10 no irq", irq_n, 1'b1);
  endtask

  task automatic t_tx;
    logic [11:0] f, e;
    logic [7:0] s;
    int len;
    bus_wr(0, 8'h15);
    bus_wr(1, 8'hA5);
    bus_wr(1, 8'h3C);
    bus_rd(0, s); chk("R1 held byte, empty low", s[1], 1'b0);
    mk(8'hA5, 8, 0, 0, 1, 0, 0, e, len);
    ser_grab(len, 16, f); chk("R4 8N1 frame A5", f, e);
    mk(8'h3C, 8, 0, 0, 1, 0, 0, e, len);
    ser_grab(len, 16, f); chk("R4 8N1 frame 3C", f, e);
    repeat (20) @(negedge clk);
    bus_rd(0, s); chk("R1 empty after send", s[1], 1'b1);
    bus_wr(0, 8'h09); bus_wr(1, 8'h35);
    mk(8'h35, 7, 1, 0, 1, 0, 0, e, len);
    ser_grab(len, 16, f); chk("R4 7E1 frame", f, e);
    repeat (20) @(negedge clk);
    bus_wr(0, 8'h1D); bus_wr(1, 8'h03);
    mk(8'h03, 8, 1, 1, 1, 0, 0, e, len);
    ser_grab(len, 16, f); chk("R4 8O1 frame", f, e);
    repeat (20) @(negedge clk);
    bus_wr(0, 8'h05); bus_wr(1, 8'h40);
    mk(8'h40, 7, 1, 1, 2, 0, 0, e, len);
    ser_grab(len, 16, f); chk("R4 7O2 frame", f, e);
    repeat (40) @(negedge clk);
  endtask

  task automatic t_div;
    int n;
    bus_wr(0, 8'h16); bus_wr(1, 8'h01);
    low_len(n); chk("R4 divide 64 bit length", n, 64);
    repeat (700) @(negedge clk);
    bus_wr(0, 8'h14); bus_wr(1, 8'h01);
    low_len(n); chk("R4 divide 1 bit length", n, 1);
    repeat (30) @(negedge clk);
  endtask

  task automatic t_rx;
    logic [11:0] f;
    logic [7:0] s;
    int len;
    bus_wr(0, 8'h95);
    repeat (4) @(negedge clk);
    mk(8'h5A, 8, 0, 0, 1, 0, 0, f, len);
    ser_send(f, len, 16);
    bus_rd(0, s); chk("R5 status after char", s, 8'h83);
    chk("R8 rx irq", irq_n, 1'b0);
    bus_rd(1, s); chk("R5 received byte", s, 8'h5A);
    chk("R11 irq one cycle late", irq_n, 1'b0);
    @(negedge clk);
    chk("R11 irq released", irq_n, 1'b1);
    bus_rd(0, s); chk("R5 full cleared by read", s, 8'h02);
    mk(8'h5A, 8, 0, 0, 1, 0, 1, f, len);
    ser_send(f, len, 16);
    bus_rd(0, s); chk("R5 framing error", s, 8'h93);
    bus_rd(1, s);
    bus_wr(0, 8'h99);
    mk(8'h5A, 8, 1, 0, 1, 1, 0, f, len);
    ser_send(f, len, 16);
    bus_rd(0, s); chk("R5 parity error", s, 8'hC3);
    bus_rd(1, s); chk("R5 byte with bad parity", s, 8'h5A);
    mk(8'h5A, 8, 1, 0, 1, 0, 0, f, len);
    ser_send(f, len, 16);
    bus_rd(0, s); chk("R5 flags cleared by good char", s, 8'h83);
    bus_rd(1, s);
    bus_wr(0, 8'h89);
    mk(8'hB7, 7, 1, 0, 1, 0, 0, f, len);
    ser_send(f, len, 16);
    bus_rd(1, s); chk("R5 seven-bit byte", s, 8'h37);
  endtask

  task automatic t_ovr;
    logic [11:0] f;
    logic [7:0] s;
    int len;
    bus_wr(0, 8'h95);
    bus_rd(1, s);
    mk(8'h11, 8, 0, 0, 1, 0, 0, f, len); ser_send(f, len, 16);
    mk(8'h22, 8, 0, 0, 1, 0, 0, f, len); ser_send(f, len, 16);
    bus_rd(0, s); chk("R6 overrun status", s, 8'hA3);
    bus_rd(1, s); chk("R6 first char kept", s, 8'h11);
    bus_rd(0, s); chk("R6 overrun cleared", s, 8'h02);
    bus_rd(1, s);
    mk(8'h33, 8, 0, 0, 1, 0, 0, f, len); ser_send(f, len, 16);
    mk(8'h44, 8, 0, 0, 1, 0, 0, f, len); ser_send(f, len, 16);
    bus_rd(1, s); chk("R6 data read alone", s, 8'h33);
    bus_rd(0, s); chk("R6 overrun kept without status read", s, 8'hA2);
    bus_rd(1, s);
    bus_rd(0, s); chk("R6 overrun cleared by sequence", s, 8'h02);
  endtask

  task automatic t_dcd;
    logic [7:0] s;
    bus_wr(0, 8'h95);
    dcd_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 irq on lost carrier", irq_n, 1'b0);
    bus_rd(0, s); chk("R7 lost carrier status", s, 8'h86);
    bus_rd(1, s);
    repeat (2) @(negedge clk);
    bus_rd(0, s); chk("R7 cleared while dcd high", s, 8'h02);
    dcd_n = 1'b0;
  endtask

  task automatic t_rie_off;
    logic [11:0] f;
    logic [7:0] s;
    int len;
    bus_wr(0, 8'h15);
    mk(8'h6C, 8, 0, 0, 1, 0, 0, f, len); ser_send(f, len, 16);
    chk("R8 no irq when disabled", irq_n, 1'b1);
    bus_rd(0, s); chk("R8 status without irq", s, 8'h03);
    bus_rd(1, s);
  endtask

  task automatic t_mreset;
    logic [11:0] f;
    logic [7:0] s;
    int len, lows;
    bus_wr(0, 8'h15);
    cts_n = 1'b1;
    mk(8'h66, 8, 0, 0, 1, 0, 0, f, len); ser_send(f, len, 16);
    bus_wr(1, 8'h77);
    bus_rd(0, s); chk("R10 before reset", s, 8'h09);
    bus_wr(0, 8'h03);
    @(negedge clk); cts_n = 1'b0;
    repeat (2) @(negedge clk);
    bus_rd(0, s); chk("R10 flags and holding cleared", s, 8'h02);
    bus_wr(0, 8'h15);
    lows = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    chk("R10 held byte dropped", lows, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    fork
      begin
        t_reset(); t_cts(); t_tx(); t_div(); t_rx();
        t_ovr(); t_dcd(); t_rie_off(); t_mreset();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule